// File: doc/BRIEF.md
# Deferred Load Return Buffer

This block sits beside one SIMD's register file and catches the data that vector memory loads bring back. A returned value does not go into its destination register as soon as it arrives. It waits in a buffer slot that software picked when it issued the load. The register stays free for other uses while the load is in flight. When a wave issues its wait-for-count instruction, the buffer starts copying that wave's returned data into the register file through one write port. The wait is reported complete once the wave's count of loads not yet copied has dropped to the threshold the instruction gives.

Each wave has its own ordered list of outstanding loads. Copies leave that list strictly in issue order. If the oldest load has not returned, the wave stalls even when younger data is already present. When several waves have copies ready, a round-robin arbiter picks one wave per cycle.

Load issue and the register-file write port are valid/ready. A load is taken on a cycle where `ld_valid` and `ld_ready` are both high. The issuer may drop an offer that was not taken. Once `rf_valid` is raised, it stays high and the address, data and wave stay unchanged until `rf_ready` accepts the beat. Memory returns and wait issues are single-cycle strobes with no back-pressure. A return is always absorbed, because its slot was reserved when the load was issued.

Top module: `ldret_buffer`

## Requirements
- R1: After reset every per-wave outstanding count is zero, every slot is free, `rf_valid` is low, `wt_done` is all zero and `ld_ready` is high. A load accepted on a free slot reserves that slot and adds one to its wave's outstanding count.
- R2: No register-file write is offered for a wave until that wave has issued a wait. Before then, returned data stays in its slot.
- R3: While a wave is waiting, each copy presents `rf_addr` equal to the load's destination index and `rf_data` equal to the returned data. One copy completes per accepted cycle, and each completed copy lowers the wave's count by one.
- R4: `wt_done[w]` pulses for exactly one cycle once wave w's outstanding count is at or below its threshold, and only after the copies that got it there. No further copies for that wave happen until it waits again. A wait on a wave with nothing outstanding completes on the next cycle without any write.
- R5: `ld_ready` is low while the addressed wave has 15 loads outstanding, so a sixteenth is held back.
- R6: Copies for one wave reach the register file in issue order. An unreturned oldest load blocks that wave even if younger loads have returned.
- R7: A load whose slot is still occupied raises `ld_err` in its handshake cycle and is discarded. It changes no count, and neither its destination nor its wave is ever written.
- R8: When several waves have copies ready, grants rotate round-robin: a wave that just copied is served again only after every other ready wave.
- R9: While `rf_valid` is high and `rf_ready` is low, `rf_valid`, `rf_addr`, `rf_data` and `rf_wave` hold their values.
- R10: A return for a slot with no load pending is ignored. A wait issued by a wave that is already waiting is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load issue offered |
| ld_ready | output | 1 | Addressed wave can take another load |
| ld_wave | input | 2 | Issuing wave |
| ld_slot | input | 5 | Buffer slot chosen by software |
| ld_dst | input | 8 | Destination register index |
| ld_err | output | 1 | Taken load hit an occupied slot and was dropped |
| ret_valid | input | 1 | Memory return strobe |
| ret_slot | input | 5 | Slot the return belongs to |
| ret_data | input | 32 | Returned data |
| wt_valid | input | 1 | Wait instruction strobe |
| wt_wave | input | 2 | Waiting wave |
| wt_thresh | input | 4 | Outstanding count the wait accepts |
| rf_valid | output | 1 | Register write offered |
| rf_ready | input | 1 | Register file accepts the write |
| rf_addr | output | 8 | Register index written |
| rf_data | output | 32 | Data written |
| rf_wave | output | 2 | Wave owning the write |
| wt_done | output | 4 | Per-wave wait-complete pulse |

## Verification
The hardest case to reach is a wave blocked by its own oldest load: younger data sits ready in the buffer, the wave is waiting, and yet nothing may be written. The stimulus returns loads in reverse or partial order and holds back the head return for several cycles. While the wave is stalled it also issues a second wait, which must be ignored. Filling a wave to its 15-load limit and offering one more is a second hard case, reached by issuing fifteen loads back to back to one wave without any returns.

// File: rtl/lrb_pkg.sv
package lrb_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_PEND = 2'd1,
    SLOT_FULL = 2'd2
  } slot_state_e;
endpackage

// File: rtl/lrb_slot_store.sv
module lrb_slot_store
  import lrb_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int REG_AW    = 8,
  parameter int DATA_W    = 32,
  localparam int SW       = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [SW-1:0]     alloc_slot,
  input  logic [REG_AW-1:0] alloc_dst,
  input  logic              fill_en,
  input  logic [SW-1:0]     fill_slot,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              free_en,
  input  logic [SW-1:0]     free_slot,
  input  logic [SW-1:0]     rd_slot,
  output logic [NUM_SLOTS-1:0] busy_vec,
  output logic [NUM_SLOTS-1:0] full_vec,
  output logic [REG_AW-1:0] rd_dst,
  output logic [DATA_W-1:0] rd_data
);
  slot_state_e       state [NUM_SLOTS];
  logic [REG_AW-1:0] dst_q [NUM_SLOTS];
  logic [DATA_W-1:0] dat_q [NUM_SLOTS];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (!rst_n) begin
        state[i] <= SLOT_FREE;
      end else if (free_en && free_slot == SW'(i)) begin
        state[i] <= SLOT_FREE;
      end else if (alloc_en && alloc_slot == SW'(i)) begin
        state[i] <= SLOT_PEND;
      end else if (fill_en && fill_slot == SW'(i) && state[i] == SLOT_PEND) begin
        state[i] <= SLOT_FULL;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (alloc_en && alloc_slot == SW'(i)) dst_q[i] <= alloc_dst;
      if (fill_en && fill_slot == SW'(i) && state[i] == SLOT_PEND) dat_q[i] <= fill_data;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      busy_vec[i] = (state[i] != SLOT_FREE);
      full_vec[i] = (state[i] == SLOT_FULL);
    end
  end

  assign rd_dst  = dst_q[rd_slot];
  assign rd_data = dat_q[rd_slot];
endmodule

// File: rtl/lrb_wave_queue.sv
module lrb_wave_queue #(
  parameter int SW    = 5,
  parameter int CNT_W = 4,
  localparam int DEPTH = 1 << CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [SW-1:0]    push_slot,
  input  logic             pop,
  output logic [SW-1:0]    head_slot,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  logic [SW-1:0]    mem [DEPTH];
  logic [CNT_W-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_slot;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assign head_slot = mem[rd_ptr];
  assign full      = (count == '1);
endmodule

// File: rtl/lrb_rr_arb.sv
module lrb_rr_arb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          advance,
  output logic          gnt_valid,
  output logic [IW-1:0] gnt_idx
);
  logic [IW-1:0] ptr, lock_idx, found;
  logic          locked, any;

  always_comb begin
    int k;
    found = '0;
    any   = 1'b0;
    for (int i = 0; i < N; i++) begin
      k = int'(ptr) + i;
      if (k >= N) k = k - N;
      if (!any && req[k]) begin
        any   = 1'b1;
        found = IW'(k);
      end
    end
  end

  assign gnt_valid = locked || any;
  assign gnt_idx   = locked ? lock_idx : found;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr      <= '0;
      locked   <= 1'b0;
      lock_idx <= '0;
    end else if (gnt_valid && advance) begin
      locked <= 1'b0;
      ptr    <= (gnt_idx == IW'(N - 1)) ? '0 : gnt_idx + 1'b1;
    end else if (gnt_valid) begin
      locked   <= 1'b1;
      lock_idx <= gnt_idx;
    end
  end
endmodule

// File: rtl/ldret_buffer.sv
module ldret_buffer
  import lrb_pkg::*;
#(
  parameter int NUM_WAVES = 4,
  parameter int NUM_SLOTS = 32,
  parameter int REG_AW    = 8,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 4,
  localparam int WW = (NUM_WAVES > 1) ? $clog2(NUM_WAVES) : 1,
  localparam int SW = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_valid,
  output logic                 ld_ready,
  input  logic [WW-1:0]        ld_wave,
  input  logic [SW-1:0]        ld_slot,
  input  logic [REG_AW-1:0]    ld_dst,
  output logic                 ld_err,
  input  logic                 ret_valid,
  input  logic [SW-1:0]        ret_slot,
  input  logic [DATA_W-1:0]    ret_data,
  input  logic                 wt_valid,
  input  logic [WW-1:0]        wt_wave,
  input  logic [CNT_W-1:0]     wt_thresh,
  output logic                 rf_valid,
  input  logic                 rf_ready,
  output logic [REG_AW-1:0]    rf_addr,
  output logic [DATA_W-1:0]    rf_data,
  output logic [WW-1:0]        rf_wave,
  output logic [NUM_WAVES-1:0] wt_done
);
  logic [NUM_SLOTS-1:0]       busy_vec, full_vec;
  logic [SW-1:0]              q_head [NUM_WAVES];
  logic [CNT_W-1:0]           q_cnt  [NUM_WAVES];
  logic [NUM_WAVES-1:0]       q_full, eligible, waiting;
  logic [CNT_W-1:0]           thr    [NUM_WAVES];
  logic [NUM_WAVES*CNT_W-1:0] cnt_flat;
  logic                       ld_fire, ld_take, rf_fire;
  logic [SW-1:0]              cp_slot;

  assign ld_ready = !q_full[ld_wave];
  assign ld_fire  = ld_valid && ld_ready;
  assign ld_err   = ld_fire && busy_vec[ld_slot];
  assign ld_take  = ld_fire && !busy_vec[ld_slot];
  assign rf_fire  = rf_valid && rf_ready;
  assign cp_slot  = q_head[rf_wave];

  lrb_slot_store #(.NUM_SLOTS(NUM_SLOTS), .REG_AW(REG_AW), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(ld_take), .alloc_slot(ld_slot), .alloc_dst(ld_dst),
    .fill_en(ret_valid), .fill_slot(ret_slot), .fill_data(ret_data),
    .free_en(rf_fire), .free_slot(cp_slot), .rd_slot(cp_slot),
    .busy_vec(busy_vec), .full_vec(full_vec),
    .rd_dst(rf_addr), .rd_data(rf_data)
  );

  for (genvar w = 0; w < NUM_WAVES; w++) begin : g_wave
    lrb_wave_queue #(.SW(SW), .CNT_W(CNT_W)) u_q (
      .clk(clk), .rst_n(rst_n),
      .push(ld_take && ld_wave == WW'(w)), .push_slot(ld_slot),
      .pop(rf_fire && rf_wave == WW'(w)),
      .head_slot(q_head[w]), .count(q_cnt[w]), .full(q_full[w])
    );

    assign wt_done[w]  = waiting[w] && (q_cnt[w] <= thr[w]);
    assign eligible[w] = waiting[w] && (q_cnt[w] > thr[w]) && full_vec[q_head[w]];
    assign cnt_flat[w*CNT_W +: CNT_W] = q_cnt[w];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        waiting[w] <= 1'b0;
        thr[w]     <= '0;
      end else if (wt_done[w]) begin
        waiting[w] <= 1'b0;
      end else if (wt_valid && wt_wave == WW'(w) && !waiting[w]) begin
        waiting[w] <= 1'b1;
        thr[w]     <= wt_thresh;
      end
    end
  end

  lrb_rr_arb #(.N(NUM_WAVES)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(eligible), .advance(rf_ready),
    .gnt_valid(rf_valid), .gnt_idx(rf_wave)
  );
endmodule

// File: rtl/lrb_checker.sv
module lrb_checker #(
  parameter int NUM_WAVES = 4,
  parameter int REG_AW    = 8,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 4,
  localparam int WW = (NUM_WAVES > 1) ? $clog2(NUM_WAVES) : 1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       ld_valid,
  input logic                       ld_ready,
  input logic                       ld_err,
  input logic [WW-1:0]              ld_wave,
  input logic                       rf_valid,
  input logic                       rf_ready,
  input logic [REG_AW-1:0]          rf_addr,
  input logic [DATA_W-1:0]          rf_data,
  input logic [WW-1:0]              rf_wave,
  input logic [NUM_WAVES-1:0]       wt_done,
  input logic [NUM_WAVES-1:0]       waiting,
  input logic [NUM_WAVES*CNT_W-1:0] cnt_flat
);
  logic [CNT_W-1:0] cnt_ld, cnt_rf, cnt_rf_m1;
  assign cnt_ld    = cnt_flat[ld_wave*CNT_W +: CNT_W];
  assign cnt_rf    = cnt_flat[rf_wave*CNT_W +: CNT_W];
  assign cnt_rf_m1 = cnt_rf - 1'b1;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && ld_ready |-> cnt_ld != '1); // R5
  AST_COPY_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    rf_valid |-> waiting[rf_wave]); // R2
  AST_ERR_IN_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_err |-> ld_valid && ld_ready); // R7
  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rf_valid && !rf_ready |=> rf_valid && $stable(rf_addr) && $stable(rf_data) && $stable(rf_wave)); // R9
  AST_COPY_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
    rf_valid && rf_ready && !(ld_valid && ld_ready && !ld_err && ld_wave == rf_wave)
    |=> cnt_flat[$past(rf_wave)*CNT_W +: CNT_W] == $past(cnt_rf_m1)); // R3

  for (genvar w = 0; w < NUM_WAVES; w++) begin : g_done
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      wt_done[w] |=> !wt_done[w]); // R4
  end
endmodule

bind ldret_buffer lrb_checker #(
  .NUM_WAVES(NUM_WAVES), .REG_AW(REG_AW), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
  .ld_err(ld_err), .ld_wave(ld_wave), .rf_valid(rf_valid), .rf_ready(rf_ready),
  .rf_addr(rf_addr), .rf_data(rf_data), .rf_wave(rf_wave), .wt_done(wt_done),
  .waiting(waiting), .cnt_flat(cnt_flat)
);

// File: tb/tb_ldret_buffer.sv
`timescale 1ns/1ps
module tb_ldret_buffer;
  localparam int NW = 4, NS = 32, RAW = 8, DW = 32, CW = 4, WW = 2, SW = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic ld_valid = 0, ld_ready, ld_err;
  logic [WW-1:0] ld_wave = '0;
  logic [SW-1:0] ld_slot = '0;
  logic [RAW-1:0] ld_dst = '0;
  logic ret_valid = 0;
  logic [SW-1:0] ret_slot = '0;
  logic [DW-1:0] ret_data = '0;
  logic wt_valid = 0;
  logic [WW-1:0] wt_wave = '0;
  logic [CW-1:0] wt_thresh = '0;
  logic rf_valid, rf_ready = 1'b1;
  logic [RAW-1:0] rf_addr;
  logic [DW-1:0] rf_data;
  logic [WW-1:0] rf_wave;
  logic [NW-1:0] wt_done;

  ldret_buffer #(.NUM_WAVES(NW), .NUM_SLOTS(NS), .REG_AW(RAW), .DATA_W(DW), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_wave(ld_wave),
    .ld_slot(ld_slot), .ld_dst(ld_dst), .ld_err(ld_err), .ret_valid(ret_valid),
    .ret_slot(ret_slot), .ret_data(ret_data), .wt_valid(wt_valid), .wt_wave(wt_wave),
    .wt_thresh(wt_thresh), .rf_valid(rf_valid), .rf_ready(rf_ready), .rf_addr(rf_addr),
    .rf_data(rf_data), .rf_wave(rf_wave), .wt_done(wt_done)
  );

  int tests = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // write log and wait-complete record, sampled mid-cycle
  logic [RAW-1:0] lg_addr [256];
  logic [DW-1:0]  lg_data [256];
  logic [WW-1:0]  lg_wave [256];
  int lg_cyc [256];
  int lg_n = 0;
  int done_cnt [NW] = '{default: 0};
  int done_cyc [NW] = '{default: 0};

  always @(negedge clk) begin
    if (rst_n) begin
      if (rf_valid && rf_ready) begin
        lg_addr[lg_n] <= rf_addr;
        lg_data[lg_n] <= rf_data;
        lg_wave[lg_n] <= rf_wave;
        lg_cyc[lg_n]  <= cyc;
        lg_n <= lg_n + 1;
      end
      for (int w = 0; w < NW; w++)
        if (wt_done[w]) begin
          done_cnt[w] <= done_cnt[w] + 1;
          done_cyc[w] <= cyc;
        end
    end
  end

  // one row per load: {wave, slot, dst, data}
  localparam int NROW = 6;
  localparam logic [46:0] TBL [NROW] = '{
    {2'd0, 5'd3,  8'h10, 32'h1111_0001},
    {2'd0, 5'd7,  8'h2A, 32'hCAFE_0002},
    {2'd0, 5'd0,  8'hFF, 32'h0BAD_0003},
    {2'd0, 5'd31, 8'h00, 32'hFFFF_FFFF},
    {2'd0, 5'd12, 8'h41, 32'h0000_0000},
    {2'd0, 5'd5,  8'h7E, 32'h8000_0005}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic issue(input int w, input int s, input int d, output bit rdy, output bit err);
    ld_valid = 1'b1; ld_wave = w[WW-1:0]; ld_slot = s[SW-1:0]; ld_dst = d[RAW-1:0];
    @(negedge clk); rdy = ld_ready; err = ld_err;
    @(posedge clk); #1; ld_valid = 1'b0;
  endtask

  task automatic ret(input int s, input logic [DW-1:0] d);
    ret_valid = 1'b1; ret_slot = s[SW-1:0]; ret_data = d;
    @(posedge clk); #1; ret_valid = 1'b0;
  endtask

  task automatic wt(input int w, input int t);
    wt_valid = 1'b1; wt_wave = w[WW-1:0]; wt_thresh = t[CW-1:0];
    @(posedge clk); #1; wt_valid = 1'b0;
  endtask

  task automatic wait_done(input int w, input int snap, input int maxc);
    int k = 0;
    while (done_cnt[w] == snap && k < maxc) begin @(posedge clk); #1; k++; end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails + 1);
    $finish;
  end

  initial begin
    bit rdy, err, ok;
    int b, snap;
    logic [RAW-1:0] first_addr;
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!rf_valid && ld_ready && wt_done == '0, "R1 reset", {rf_valid, ld_ready, wt_done}, 6'b010000);
    @(posedge clk); #1;

    // table walk: issue all, return in reverse, then wait
    b = lg_n; ok = 1;
    for (int i = 0; i < NROW; i++) begin
      issue(TBL[i][46:45], TBL[i][44:40], TBL[i][39:32], rdy, err);
      if (!rdy || err) ok = 0;
    end
    chk(ok, "R1 loads accepted", ok, 1);
    for (int i = NROW - 1; i >= 0; i--) ret(TBL[i][44:40], TBL[i][31:0]);
    ok = 1;
    repeat (5) begin @(negedge clk); if (rf_valid) ok = 0; end
    @(posedge clk); #1;
    chk(ok && lg_n == b, "R2 no write before wait", lg_n - b, 0);
    snap = done_cnt[0];
    wt(0, 0);
    wait_done(0, snap, 60);
    chk(lg_n - b == NROW, "R3 write count", lg_n - b, NROW);
    for (int i = 0; i < NROW; i++)
      chk(lg_addr[b+i] == TBL[i][39:32] && lg_data[b+i] == TBL[i][31:0], "R6 order/R3 data",
          {lg_addr[b+i], lg_data[b+i]}, {TBL[i][39:32], TBL[i][31:0]});
    chk(lg_cyc[b+NROW-1] - lg_cyc[b] == NROW - 1, "R3 one per cycle", lg_cyc[b+NROW-1] - lg_cyc[b], NROW - 1);
    chk(done_cyc[0] > lg_cyc[b+NROW-1], "R4 done after copies", done_cyc[0], lg_cyc[b+NROW-1] + 1);

    // threshold stops copying early
    b = lg_n;
    issue(1, 1, 'h31, rdy, err); issue(1, 2, 'h32, rdy, err); issue(1, 4, 'h33, rdy, err);
    ret(1, 32'hA1); ret(2, 32'hA2); ret(4, 32'hA3);
    snap = done_cnt[1];
    wt(1, 1);
    wait_done(1, snap, 30);
    idle(5);
    chk(lg_n - b == 2 && done_cnt[1] == snap + 1, "R4 threshold", lg_n - b, 2);
    snap = done_cnt[1];
    wt(1, 0);
    wait_done(1, snap, 30);
    chk(lg_n - b == 3 && lg_addr[b+2] == 8'h33, "R4 rest kept", lg_addr[b+2], 8'h33);

    // head not returned blocks younger data; second wait ignored
    b = lg_n;
    issue(2, 6, 'h61, rdy, err); issue(2, 8, 'h62, rdy, err);
    ret(8, 32'hB2);
    snap = done_cnt[2];
    wt(2, 0);
    idle(8);
    chk(lg_n == b, "R6 head blocks", lg_n - b, 0);
    wt(2, 5);
    idle(3);
    chk(done_cnt[2] == snap, "R10 wait while waiting", done_cnt[2] - snap, 0);
    ret(6, 32'hB1);
    wait_done(2, snap, 30);
    chk(lg_n - b == 2 && lg_addr[b] == 8'h61 && lg_addr[b+1] == 8'h62, "R6 in order",
        {lg_addr[b], lg_addr[b+1]}, 16'h6162);

    // occupied slot
    b = lg_n;
    issue(0, 9, 'h50, rdy, err);
    chk(rdy && !err, "R7 first load", err, 0);
    issue(1, 9, 'h60, rdy, err);
    chk(rdy && err, "R7 busy slot flagged", err, 1);
    ret(9, 32'hC9);
    snap = done_cnt[1];
    wt(1, 0);
    wait_done(1, snap, 10);
    chk(done_cnt[1] == snap + 1 && lg_n == b, "R7 rejected load not counted", lg_n - b, 0);
    snap = done_cnt[0];
    wt(0, 0);
    wait_done(0, snap, 20);
    chk(lg_n - b == 1 && lg_addr[b] == 8'h50 && lg_data[b] == 32'hC9, "R7 original kept",
        {lg_addr[b], lg_data[b]}, {8'h50, 32'hC9});

    // stray return to a free slot
    b = lg_n;
    ret(20, 32'hDEAD);
    issue(0, 20, 'h77, rdy, err);
    snap = done_cnt[0];
    wt(0, 0);
    idle(6);
    chk(lg_n == b, "R10 stray return ignored", lg_n - b, 0);
    ret(20, 32'h1234);
    wait_done(0, snap, 20);
    chk(lg_n - b == 1 && lg_data[b] == 32'h1234 && lg_addr[b] == 8'h77, "R10 real data", lg_data[b], 32'h1234);

    // fifteen outstanding limit
    ok = 1;
    for (int i = 0; i < 15; i++) begin
      issue(3, 11 + i, 'h80 + i, rdy, err);
      if (!rdy || err) ok = 0;
    end
    chk(ok, "R1 fifteen accepted", ok, 1);
    issue(3, 26, 'h90, rdy, err);
    chk(!rdy, "R5 sixteenth held", rdy, 0);
    b = lg_n;
    ret(11, 32'hA0);
    snap = done_cnt[3];
    wt(3, 14);
    wait_done(3, snap, 20);
    chk(lg_n - b == 1 && lg_addr[b] == 8'h80 && lg_data[b] == 32'hA0, "R3 single copy", lg_addr[b], 8'h80);
    ld_wave = 2'd3;
    @(negedge clk);
    chk(ld_ready, "R5 room again", ld_ready, 1);
    @(posedge clk); #1;

    // round robin and back-pressure
    b = lg_n;
    issue(0, 26, 'hA0, rdy, err); issue(0, 27, 'hA1, rdy, err);
    issue(1, 28, 'hB0, rdy, err); issue(1, 29, 'hB1, rdy, err);
    ret(26, 32'h10); ret(27, 32'h11); ret(28, 32'h20); ret(29, 32'h21);
    rf_ready = 1'b0;
    wt(0, 0); wt(1, 0);
    @(negedge clk);
    first_addr = rf_addr; ok = rf_valid;
    repeat (3) begin @(negedge clk); if (!rf_valid || rf_addr != first_addr) ok = 0; end
    @(posedge clk); #1;
    chk(ok, "R9 held under back-pressure", rf_addr, first_addr);
    snap = done_cnt[1];
    rf_ready = 1'b1;
    wait_done(1, snap, 30);
    idle(3);
    chk(lg_n - b == 4, "R8 all copied", lg_n - b, 4);
    chk(lg_wave[b] != lg_wave[b+1] && lg_wave[b+1] != lg_wave[b+2] && lg_wave[b+2] != lg_wave[b+3],
        "R8 alternating", {lg_wave[b], lg_wave[b+1], lg_wave[b+2], lg_wave[b+3]}, 8'h11);
    chk(lg_addr[b+2] == lg_addr[b] + 1 && lg_addr[b+3] == lg_addr[b+1] + 1, "R6 per-wave order",
        {lg_addr[b+2], lg_addr[b+3]}, {lg_addr[b] + 8'd1, lg_addr[b+1] + 8'd1});
    chk(lg_addr[b] == first_addr, "R9 held beat written", lg_addr[b], first_addr);

    // wait with nothing outstanding
    b = lg_n;
    snap = done_cnt[2];
    wt(2, 0);
    wait_done(2, snap, 5);
    chk(done_cnt[2] == snap + 1 && lg_n == b, "R4 empty wait", done_cnt[2] - snap, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule